// File: doc/BRIEF.md
# Timed Receive Stream Command Controller

This block sits between a decimated sample source and a sample FIFO. Software queues receive commands through a small write-only settings bus. Each command gives a sample count, says whether capture starts at once or at a 64-bit timestamp, and says whether it chains into the next queued command. While a command is being served the block raises `run`. It then forwards every sample that arrives with the input strobe high as one FIFO entry, made of the current time, five status flags and the sample word.

Problems are reported in-band as error entries:
- a timed command whose start time has already passed at the head of the queue (late start);
- a chained command that finishes with nothing queued after it (broken chain);
- a strobe that arrives while the previous entry is still waiting for the downstream side (overrun).

After an error entry the block does not serve another command until that entry has been taken. A synchronous clear empties the command queue, drops any entry that has not been taken and returns the block to idle.

Top module: `rx_stream_ctrl`

## Requirements
- R1: While reset is high and right after it, `run`, `overrun` and `fifo_valid` are low.
- R2: A write at address 2 (ticks) queues a command built from the last word written at address 0 and the last word written at address 1. The address 0 word is laid out as bit 31 immediate, bit 30 chain, bits 28:0 sample count. The address 1 word holds the start-time upper 32 bits and the ticks word the lower 32 bits. The queue holds 8 commands, served first in, first out.
- R3: `fifo_data` is {time[63:0], flags[4:0], sample}, with flag bit 0 start-of-burst, bit 1 end-of-burst, bit 2 overrun, bit 3 late and bit 4 broken chain. A sample becomes an entry only on a cycle where `strobe` and `run` are high. The entry carries the time of that cycle and the sample word of that cycle.
- R4: An immediate, unchained command of N>0 samples yields exactly N entries. Start-of-burst is set on the first, end-of-burst on the last (both when N=1), and no flag on any other.
- R5: A timed command whose start time is still ahead waits with `run` low. Its first entry carries the time one tick after the start time.
- R6: A timed command whose start time is below the current time when it reaches the head of the queue captures nothing. It yields one entry with flags late and end-of-burst and a zero sample.
- R7: When a chained command ends and a non-empty command is queued, capture continues without a gap. Start-of-burst appears only on the very first entry and end-of-burst only on the last entry of the final command.
- R8: A zero-sample command that follows a chained command ends the burst. The end-of-burst flag goes on the last sample, and no extra entry and no error are produced.
- R9: A chained command that ends with an empty queue puts end-of-burst on none of its samples. Its last sample is followed by one entry with flags broken chain and end-of-burst.
- R10: A strobe during capture while an entry is held (`fifo_valid` high, `fifo_ready` low) pulses `overrun` for one cycle and stops capture. After the held entry, one entry with flags overrun and end-of-burst follows. No later command starts before that error entry has been taken.
- R11: While `fifo_valid` is high and `fifo_ready` low, `fifo_valid` stays high and `fifo_data` does not change.
- R12: A cycle with `clear` high leaves `run` and `fifo_valid` low on the next cycle and discards every queued command.
- R13: A lone zero-sample command produces no entry and never raises `run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Synchronous flush of queue, capture and held entry |
| cfg_stb | input | 1 | Settings write strobe |
| cfg_addr | input | 8 | Settings write address |
| cfg_data | input | 32 | Settings write data |
| now_time | input | 64 | Current timestamp |
| strobe | input | 1 | Sample valid from the decimator |
| sample | input | 32*CHANS | Sample word, 32 bits per channel |
| run | output | 1 | High while capturing |
| overrun | output | 1 | One-cycle pulse on overrun |
| fifo_data | output | 69+32*CHANS | Entry: time, flags, sample |
| fifo_valid | output | 1 | Entry present |
| fifo_ready | input | 1 | Downstream takes the entry |

## Verification
Overrun detection and end-of-count can fall on the same cycle. This happens when the strobe for a command's last sample arrives while the previous entry is still held. The bench provokes it with a two-sample command, downstream held off and a second command queued behind it. The correct outcome is one overrun pulse and an entry order of first sample, overrun error, then the second command's full burst, with no end-of-burst sample for the cut-short command.

// File: rtl/rx_stream_pkg.sv
package rx_stream_pkg;
  localparam int FLAG_W  = 5;
  localparam int LINES_W = 29;
  localparam int FLG_SOB = 0;
  localparam int FLG_EOB = 1;
  localparam int FLG_OVR = 2;
  localparam int FLG_LATE = 3;
  localparam int FLG_BRK = 4;
  localparam logic [7:0] CFG_CMD   = 8'd0;
  localparam logic [7:0] CFG_SECS  = 8'd1;
  localparam logic [7:0] CFG_TICKS = 8'd2;

  typedef struct packed {
    logic               imm;
    logic               chain;
    logic [LINES_W-1:0] lines;
    logic [63:0]        start;
  } rx_cmd_t;

  typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_RUN, ST_ERR, ST_DRAIN} rx_state_e;

  function automatic logic start_missed(input logic [63:0] start, input logic [63:0] now);
    return start < now;
  endfunction

  function automatic logic [FLAG_W-1:0] mk_flags(input logic sob, input logic eob,
                                                 input logic ovr, input logic late,
                                                 input logic brk);
    logic [FLAG_W-1:0] f;
    f = '0;
    f[FLG_SOB] = sob;
    f[FLG_EOB] = eob;
    f[FLG_OVR] = ovr;
    f[FLG_LATE] = late;
    f[FLG_BRK] = brk;
    return f;
  endfunction
endpackage

// File: rtl/rx_cmd_queue.sv
module rx_cmd_queue import rx_stream_pkg::*; #(
  parameter int DEPTH = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    clear,
  input  logic    push,
  input  rx_cmd_t din,
  input  logic    pop,
  output rx_cmd_t head,
  output logic    empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  rx_cmd_t        mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  count;
  logic           full, do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/rx_entry_reg.sv
module rx_entry_reg #(
  parameter int W = 101
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         free
);
  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready && !clear) |=> (valid && $stable(dout)));
  // R10
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst) load |-> free);
endmodule

// File: rtl/rx_stream_ctrl.sv
module rx_stream_ctrl import rx_stream_pkg::*; #(
  parameter int CHANS  = 1,
  parameter int QDEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clear,
  input  logic                          cfg_stb,
  input  logic [7:0]                    cfg_addr,
  input  logic [31:0]                   cfg_data,
  input  logic [63:0]                   now_time,
  input  logic                          strobe,
  input  logic [32*CHANS-1:0]           sample,
  output logic                          run,
  output logic                          overrun,
  output logic [64+FLAG_W+32*CHANS-1:0] fifo_data,
  output logic                          fifo_valid,
  input  logic                          fifo_ready
);
  localparam int SW = 32 * CHANS;
  localparam int EW = 64 + FLAG_W + SW;

  // settings assembly
  logic [LINES_W+1:0] cw_q;
  logic [31:0]        secs_q;
  logic               push_cmd;
  rx_cmd_t            new_cmd;
  logic               unused_reload;

  assign unused_reload = cfg_data[29];
  assign push_cmd = cfg_stb && (cfg_addr == CFG_TICKS);
  assign new_cmd  = '{imm: cw_q[LINES_W+1], chain: cw_q[LINES_W],
                      lines: cw_q[LINES_W-1:0], start: {secs_q, cfg_data}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cw_q   <= '0;
      secs_q <= '0;
    end else if (cfg_stb) begin
      if (cfg_addr == CFG_CMD)  cw_q   <= {cfg_data[31:30], cfg_data[LINES_W-1:0]};
      if (cfg_addr == CFG_SECS) secs_q <= cfg_data;
    end
  end

  // command queue
  rx_cmd_t head;
  logic    q_empty, q_pop;

  rx_cmd_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst), .clear(clear), .push(push_cmd), .din(new_cmd),
    .pop(q_pop), .head(head), .empty(q_empty));

  // control state
  rx_state_e          state;
  logic [LINES_W-1:0] remaining;
  logic               cur_chain, first_q;
  logic [63:0]        start_q;
  logic [FLAG_W-1:0]  err_flags_q;

  logic slot_free, in_run, accept, ovr_ev, last_acc;
  logic chain_next, term_zero, brk_ev, eob_now, idle_pop, err_load, ent_load, head_late;
  logic [EW-1:0] ent_din;

  assign in_run     = (state == ST_RUN);
  assign accept     = in_run && strobe && slot_free;
  assign ovr_ev     = in_run && strobe && !slot_free;
  assign last_acc   = accept && (remaining == LINES_W'(1));
  assign chain_next = last_acc && cur_chain && !q_empty;
  assign term_zero  = chain_next && (head.lines == '0);
  assign brk_ev     = last_acc && cur_chain && q_empty;
  assign eob_now    = last_acc && (!cur_chain || term_zero);
  assign idle_pop   = (state == ST_IDLE) && !q_empty;
  assign q_pop      = idle_pop || chain_next;
  assign err_load   = (state == ST_ERR) && slot_free;
  assign ent_load   = accept || err_load;
  assign head_late  = !head.imm && start_missed(head.start, now_time);
  assign ent_din    = accept ? {now_time, mk_flags(first_q, eob_now, 1'b0, 1'b0, 1'b0), sample}
                             : {now_time, err_flags_q, {SW{1'b0}}};

  assign run     = in_run;
  assign overrun = ovr_ev;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state       <= ST_IDLE;
      remaining   <= '0;
      cur_chain   <= 1'b0;
      first_q     <= 1'b0;
      start_q     <= '0;
      err_flags_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (!q_empty) begin
          cur_chain <= head.chain;
          remaining <= head.lines;
          start_q   <= head.start;
          first_q   <= 1'b1;
          if (head.lines == '0)          state <= ST_IDLE;
          else if (head.imm)             state <= ST_RUN;
          else if (head_late) begin
            err_flags_q <= mk_flags(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
            state       <= ST_ERR;
          end
          else if (head.start == now_time) state <= ST_RUN;
          else                           state <= ST_WAIT;
        end
        ST_WAIT: if (now_time >= start_q) state <= ST_RUN;
        ST_RUN: begin
          if (ovr_ev) begin
            err_flags_q <= mk_flags(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
            state       <= ST_ERR;
          end else if (accept) begin
            first_q   <= 1'b0;
            remaining <= remaining - LINES_W'(1);
            if (last_acc) begin
              if (brk_ev) begin
                err_flags_q <= mk_flags(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
                state       <= ST_ERR;
              end else if (chain_next && !term_zero) begin
                remaining <= head.lines;
                cur_chain <= head.chain;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
        end
        ST_ERR:   if (slot_free) state <= ST_DRAIN;
        ST_DRAIN: if (fifo_valid && fifo_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  rx_entry_reg #(.W(EW)) u_entry (
    .clk(clk), .rst(rst), .clear(clear), .load(ent_load), .din(ent_din),
    .ready(fifo_ready), .valid(fifo_valid), .dout(fifo_data), .free(slot_free));

  // R10
  ovr_pulse_chk: assert property (@(posedge clk) disable iff (rst) overrun |=> (!overrun && !run));
  // R12
  clear_idle_chk: assert property (@(posedge clk) disable iff (rst) clear |=> (!run && !fifo_valid));
  // R6
  late_norun_chk: assert property (@(posedge clk) disable iff (rst || clear)
    (idle_pop && head.lines != '0 && head_late) |=> !run);
  // R4
  eob_stop_chk: assert property (@(posedge clk) disable iff (rst || clear) eob_now |=> !run);
endmodule

// File: tb/rx_stream_ctrl_bench.sv
module rx_stream_ctrl_bench;
  localparam int EW = 101;
  localparam int NV = 5;
  localparam int unsigned TV_LINES [NV] = '{1, 3, 8, 0, 13};
  localparam int unsigned TV_PER   [NV] = '{1, 1, 2, 1, 3};

  logic        clk = 0, rst = 1, clear = 0;
  logic        cfg_stb = 0;
  logic [7:0]  cfg_addr = 0;
  logic [31:0] cfg_data = 0;
  logic [63:0] now_time = 0;
  logic        strobe;
  logic [31:0] sample;
  logic        run, overrun, fifo_valid;
  logic        fifo_ready = 1;
  logic [EW-1:0] fifo_data;
  int unsigned per = 1;

  int total = 0, bad = 0, n_ent = 0, run_cyc = 0, ovr_cnt = 0;
  logic done = 0;
  logic [63:0] e_time [512];
  logic [4:0]  e_flg  [512];
  logic [31:0] e_smp  [512];

  always #4 clk = ~clk;

  assign strobe = (now_time % 64'(per)) == 64'd0;
  assign sample = now_time[31:0];

  always @(posedge clk) begin
    #1 now_time <= now_time + 64'd1;
  end

  rx_stream_ctrl u_rx_stream_ctrl (
    .clk(clk), .rst(rst), .clear(clear), .cfg_stb(cfg_stb), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .now_time(now_time), .strobe(strobe), .sample(sample),
    .run(run), .overrun(overrun), .fifo_data(fifo_data), .fifo_valid(fifo_valid),
    .fifo_ready(fifo_ready));

  always @(negedge clk) begin
    if (!rst) begin
      if (fifo_valid && fifo_ready && n_ent < 512) begin
        e_time[n_ent] = fifo_data[100:37];
        e_flg[n_ent]  = fifo_data[36:32];
        e_smp[n_ent]  = fifo_data[31:0];
        n_ent = n_ent + 1;
      end
      if (run) run_cyc = run_cyc + 1;
      if (overrun) ovr_cnt = ovr_cnt + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_log();
    n_ent = 0; run_cyc = 0; ovr_cnt = 0;
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_stb = 1; cfg_addr = a; cfg_data = d;
  endtask

  task automatic send_cmd(input logic imm, input logic chain, input logic [28:0] lines,
                          input logic [63:0] st);
    cfg_wr(8'd0, {imm, chain, 1'b0, lines});
    cfg_wr(8'd1, st[63:32]);
    cfg_wr(8'd2, st[31:0]);
    @(posedge clk); #1;
    cfg_stb = 0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // burst of n plain samples with strobe period p (R3, R4)
  task automatic check_burst(input int n, input int p, input string tag);
    chk(n_ent == n, tag, 64'(n_ent), 64'(n));
    for (int i = 0; i < n && i < n_ent; i++) begin
      logic [4:0] ef;
      ef = {3'b000, (i == n - 1), (i == 0)};
      chk(e_flg[i] == ef, tag, 64'(e_flg[i]), 64'(ef));
      chk(e_smp[i] == e_time[i][31:0], "R3 sample/time pairing", 64'(e_smp[i]), e_time[i]);
      if (i > 0)
        chk(e_time[i] == e_time[i-1] + 64'(p), "R3 strobe gating", e_time[i], e_time[i-1] + 64'(p));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total = total + 1; bad = bad + 1;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] st;
    logic [EW-1:0] held;
    cycles(3);
    chk(run == 0, "R1 run in reset", 64'(run), 0);
    chk(fifo_valid == 0, "R1 valid in reset", 64'(fifo_valid), 0);
    chk(overrun == 0, "R1 overrun in reset", 64'(overrun), 0);
    rst = 0;
    cycles(2);
    chk(run == 0 && fifo_valid == 0, "R1 after reset", 64'({run, fifo_valid}), 0);

    // table of immediate single commands (R4, R13)
    for (int v = 0; v < NV; v++) begin
      per = TV_PER[v];
      clr_log();
      send_cmd(1, 0, 29'(TV_LINES[v]), 0);
      cycles(int'(TV_LINES[v] * TV_PER[v]) + 30);
      check_burst(int'(TV_LINES[v]), int'(TV_PER[v]), "R4 immediate burst");
      if (TV_LINES[v] == 0) chk(run_cyc == 0, "R13 zero-sample run", 64'(run_cyc), 0);
    end
    per = 1;

    // R5 timed start
    clr_log();
    st = now_time + 64'd40;
    send_cmd(0, 0, 4, st);
    cycles(20);
    chk(run_cyc == 0 && n_ent == 0, "R5 waiting", 64'(run_cyc), 0);
    cycles(60);
    check_burst(4, 1, "R5 timed burst");
    chk(e_time[0] == st + 64'd1, "R5 first time", e_time[0], st + 64'd1);

    // R6 late start
    clr_log();
    st = now_time - 64'd3;
    send_cmd(0, 0, 4, st);
    cycles(20);
    chk(n_ent == 1, "R6 late count", 64'(n_ent), 1);
    chk(e_flg[0] == 5'b01010, "R6 late flags", 64'(e_flg[0]), 64'(5'b01010));
    chk(e_smp[0] == 0, "R6 late sample", 64'(e_smp[0]), 0);
    chk(run_cyc == 0, "R6 no run", 64'(run_cyc), 0);

    // R7 seamless chain
    clr_log();
    send_cmd(1, 1, 20, 0);
    send_cmd(1, 0, 5, 0);
    cycles(60);
    check_burst(25, 1, "R7 chained burst");

    // R8 zero-sample terminator
    clr_log();
    send_cmd(1, 1, 20, 0);
    send_cmd(1, 0, 0, 0);
    cycles(60);
    check_burst(20, 1, "R8 zero terminator");

    // R9 broken chain
    clr_log();
    send_cmd(1, 1, 6, 0);
    cycles(30);
    chk(n_ent == 7, "R9 count", 64'(n_ent), 7);
    chk(e_flg[0] == 5'b00001, "R9 first", 64'(e_flg[0]), 1);
    chk(e_flg[5] == 5'b00000, "R9 last sample no eob", 64'(e_flg[5]), 0);
    chk(e_flg[6] == 5'b10010, "R9 broken entry", 64'(e_flg[6]), 64'(5'b10010));

    // R10/R11 overrun on the final sample, second command waits
    clr_log();
    fifo_ready = 0;
    send_cmd(1, 0, 2, 0);
    send_cmd(1, 0, 3, 0);
    cycles(20);
    chk(ovr_cnt == 1, "R10 overrun pulses", 64'(ovr_cnt), 1);
    chk(run == 0, "R10 capture stopped", 64'(run), 0);
    chk(fifo_valid == 1, "R11 held valid", 64'(fifo_valid), 1);
    held = fifo_data;
    cycles(5);
    chk(fifo_data == held, "R11 held data", fifo_data[63:0], held[63:0]);
    fifo_ready = 1;
    cycles(30);
    chk(n_ent == 5, "R10 entry count", 64'(n_ent), 5);
    chk(e_flg[0] == 5'b00001, "R10 first sample", 64'(e_flg[0]), 1);
    chk(e_flg[1] == 5'b00110, "R10 overrun entry", 64'(e_flg[1]), 64'(5'b00110));
    chk(e_flg[2] == 5'b00001 && e_flg[4] == 5'b00010, "R10 next command after error",
        64'({e_flg[2], e_flg[4]}), 64'({5'b00001, 5'b00010}));

    // R12 clear
    clr_log();
    send_cmd(1, 0, 60, 0);
    send_cmd(0, 0, 4, now_time + 64'd3000);
    cycles(10);
    clear = 1;
    cycles(1);
    clear = 0;
    chk(run == 0, "R12 run after clear", 64'(run), 0);
    chk(fifo_valid == 0, "R12 valid after clear", 64'(fifo_valid), 0);
    clr_log();
    cycles(3100);
    chk(n_ent == 0, "R12 queue flushed", 64'(n_ent), 0);
    send_cmd(1, 0, 2, 0);
    cycles(20);
    check_burst(2, 1, "R12 usable after clear");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule